// File: doc/BRIEF.md
# Big-Number Accelerator Command Register Bank

This block is the host-side register file of a word-serial big-number arithmetic engine. The host uses a simple synchronous bus with word offsets. Through it the host loads four vector base addresses into operand memory, two operand lengths in 32-bit words, a bit-shift amount and a function word. The function word selects one basic operation or one sequencer operation. Setting its run flag launches the datapath with a one-cycle start pulse. When the datapath signals completion, the block latches the comparison outcome and the two most-significant-word indicators, then drops the run flag. The interrupt output is the inverse of the run flag.

The host may prepare the next operation while the current one executes. During that time, writes to an address or length register land in a shadow copy. The shadow copy is moved into the live register only when the next run is accepted. The shift amount cannot be changed while the engine is busy. A stall flag in the function word lets the host freeze the visible result. While the flag is set, the block parks the datapath's finishing status and keeps the run flag set. It releases both in the cycle the host clears the flag.

Top module: `bnacc_cmd_regs`

## Requirements
- R1: The four vector address registers sit at word offsets 2 (A), 3 (B), 4 (C) and 5 (D). Each keeps only bits [10:0] of the written word, reads back zero-extended and drives `dp_ptr_a`..`dp_ptr_d`. An idle write is visible in the cycle after the write.
- R2: The length registers sit at offsets 6 (A) and 7 (B). Each keeps bits [8:0] and drives `dp_len_a`/`dp_len_b`.
- R3: While run is set, a write to offsets 2 to 7 leaves the live value, its readback and its `dp_*` output unchanged. The written value becomes live in the cycle after the next run is accepted. A register that was not written keeps its value across that start. A write in the same cycle as `dp_done` is still shadowed.
- R4: An idle write to offsets 2 to 7 takes effect at once and discards any shadow value left from a write made during an earlier run.
- R5: The shift register at offset 1 keeps bits [4:0] and drives `dp_shift`. Writes while run is set are ignored.
- R6: The function word sits at offset 0. Bits [14:0] hold the operation field: multiply 0, add/sub 1, MS-one 3, add 4, subtract 5, right shift 6, left shift 7, divide 8, modulo 9, compare 10, copy 11, sequencer code [14:12]. Bit 15 is run and bit 24 is stall, and readback has this same layout. An idle write stores the field and stall. If bit 15 is set, run reads 1 from the next cycle, `dp_start` pulses for exactly that cycle, and `dp_func` shows the field.
- R7: While run is set, a function write with bit 15 set is ignored entirely. A function write with bit 15 clear changes only the stall bit.
- R8: `dp_done` while run is set and stall is clear does two things in the next cycle. The compare result (3 bits, offset 8) shows `dp_cmp`. The MSW (offset 9) and remainder-MSW (offset 10) show `dp_msw`/`dp_rem` masked to bits 15 and [10:0]. Run clears in the same cycle. `dp_done` while idle changes nothing.
- R9: If stall is set after a cycle's writes and `dp_done` arrives, the status registers and run stay unchanged for as long as stall stays set. The parked values commit, and run clears, in the cycle after the write that clears stall. A done that arrives in the same cycle as the write that clears stall commits directly.
- R10: `irq` equals the inverse of the run bit at all times.
- R11: After synchronous reset every register reads 0, run is 0, `irq` is 1 and `dp_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dp_start | output | 1 | One-cycle launch pulse to datapath |
| dp_func | output | 15 | Live operation field |
| dp_ptr_a | output | 11 | Live vector A address |
| dp_ptr_b | output | 11 | Live vector B address |
| dp_ptr_c | output | 11 | Live vector C address |
| dp_ptr_d | output | 11 | Live vector D address |
| dp_len_a | output | 9 | Live vector A length |
| dp_len_b | output | 9 | Live vector B length |
| dp_shift | output | 5 | Live shift amount |
| dp_done | input | 1 | Datapath completion pulse |
| dp_cmp | input | 3 | Compare outcome from datapath |
| dp_msw | input | 16 | Result MSW indicator from datapath |
| dp_rem | input | 16 | Remainder MSW indicator from datapath |
| irq | output | 1 | Interrupt, inverse of run |

## Verification
The hard cases are cycles in which the datapath's completion pulse coincides with a host write. The bench makes a done pulse meet a pointer write, a write that clears stall, and a write that sets stall. It then judges the register the write targeted, the status registers and the run flag against a behavioural model that resolves each pairing by the requirement rules. Directed checks with literal values confirm the three outcomes: the write is shadowed, the status commits directly, and the status is parked.

// File: rtl/bnacc_pkg.sv
package bnacc_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int PTR_W   = 11;
    localparam int LEN_W   = 9;
    localparam int SHIFT_W = 5;
    localparam int OP_W    = 15;
    localparam int CMP_W   = 3;
    localparam int MSW_W   = 16;
    localparam int N_VEC   = 4;
    localparam int N_LEN   = 2;

    localparam int RUN_BIT   = 15;
    localparam int STALL_BIT = 24;

    localparam int OFS_FUNC  = 0;
    localparam int OFS_SHIFT = 1;
    localparam int OFS_VEC0  = 2;
    localparam int OFS_LEN0  = OFS_VEC0 + N_VEC;
    localparam int OFS_CMP   = OFS_LEN0 + N_LEN;
    localparam int OFS_MSW   = OFS_CMP + 1;
    localparam int OFS_REM   = OFS_MSW + 1;

    localparam logic [MSW_W-1:0] MSW_KEEP = 16'h87FF;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic [MSW_W-1:0] msw;
        logic [MSW_W-1:0] rem;
    } bn_status_t;

    function automatic bn_status_t keep_status(bn_status_t s);
        bn_status_t o;
        o.cmp = s.cmp;
        o.msw = s.msw & MSW_KEEP;
        o.rem = s.rem & MSW_KEEP;
        return o;
    endfunction
endpackage

// File: rtl/bnacc_dbuf_reg.sv
module bnacc_dbuf_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         busy,
    input  logic         load,
    output logic [W-1:0] active
);
    logic [W-1:0] act_q, shd_q;
    logic         pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            shd_q  <= '0;
            pend_q <= 1'b0;
        end else if (wr && !busy) begin
            act_q  <= wdata;
            pend_q <= 1'b0;
        end else if (wr) begin
            shd_q  <= wdata;
            pend_q <= 1'b1;
        end else if (load && pend_q) begin
            act_q  <= shd_q;
            pend_q <= 1'b0;
        end
    end

    assign active = act_q;

    // R3
    busy_stable_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(act_q));
endmodule

// File: rtl/bnacc_ctrl.sv
module bnacc_ctrl
    import bnacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               func_wr,
    input  logic [OP_W-1:0]    wr_op,
    input  logic               wr_run,
    input  logic               wr_stall,
    input  logic               shift_wr,
    input  logic [SHIFT_W-1:0] wr_shift,
    input  logic               dp_done,
    input  bn_status_t         dp_stat,
    output logic               run,
    output logic               stall,
    output logic               accept,
    output logic               start,
    output logic [OP_W-1:0]    op,
    output logic [SHIFT_W-1:0] shift,
    output bn_status_t         stat
);
    logic               run_q, stall_q, start_q, pend_q;
    logic [OP_W-1:0]    op_q;
    logic [SHIFT_W-1:0] shift_q;
    bn_status_t         stat_q, park_q;
    logic               stall_nxt, direct, park, release_c;

    assign accept    = func_wr && !run_q && wr_run;
    assign stall_nxt = (func_wr && !(run_q && wr_run)) ? wr_stall : stall_q;
    assign direct    = run_q && dp_done && !stall_nxt;
    assign park      = run_q && dp_done && stall_nxt;
    assign release_c = run_q && pend_q && !dp_done && !stall_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            stall_q <= 1'b0;
            start_q <= 1'b0;
            pend_q  <= 1'b0;
            op_q    <= '0;
            shift_q <= '0;
            stat_q  <= '0;
            park_q  <= '0;
        end else begin
            stall_q <= stall_nxt;
            start_q <= accept;
            if (func_wr && !run_q) op_q <= wr_op;
            if (shift_wr && !run_q) shift_q <= wr_shift;
            if (accept) run_q <= 1'b1;
            else if (direct || release_c) run_q <= 1'b0;
            if (direct) stat_q <= keep_status(dp_stat);
            else if (release_c) stat_q <= park_q;
            if (park) begin
                park_q <= keep_status(dp_stat);
                pend_q <= 1'b1;
            end else if (direct || release_c) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign run   = run_q;
    assign stall = stall_q;
    assign start = start_q;
    assign op    = op_q;
    assign shift = shift_q;
    assign stat  = stat_q;

    // R5
    shift_lock_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |=> $stable(shift_q));
    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && !dp_done && !pend_q |=> run_q);
    // R8
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(stat_q));
    // R9
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run_q && stall_nxt |=> run_q && $stable(stat_q));
    // R9
    park_run_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> run_q);
    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $rose(run_q));
endmodule

// File: rtl/bnacc_cmd_regs.sv
module bnacc_cmd_regs
    import bnacc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               dp_start,
    output logic [OP_W-1:0]    dp_func,
    output logic [PTR_W-1:0]   dp_ptr_a,
    output logic [PTR_W-1:0]   dp_ptr_b,
    output logic [PTR_W-1:0]   dp_ptr_c,
    output logic [PTR_W-1:0]   dp_ptr_d,
    output logic [LEN_W-1:0]   dp_len_a,
    output logic [LEN_W-1:0]   dp_len_b,
    output logic [SHIFT_W-1:0] dp_shift,
    input  logic               dp_done,
    input  logic [CMP_W-1:0]   dp_cmp,
    input  logic [MSW_W-1:0]   dp_msw,
    input  logic [MSW_W-1:0]   dp_rem,
    output logic               irq
);
    logic               run, stall, accept;
    logic [OP_W-1:0]    op;
    logic [SHIFT_W-1:0] shift;
    bn_status_t         stat, dp_stat;
    logic [PTR_W-1:0]   vec_act [N_VEC];
    logic [LEN_W-1:0]   len_act [N_LEN];
    logic               func_wr, shift_wr;
    logic               wdata_unused;

    assign func_wr      = bus_we && (bus_addr == ADDR_W'(OFS_FUNC));
    assign shift_wr     = bus_we && (bus_addr == ADDR_W'(OFS_SHIFT));
    assign wdata_unused = ^{bus_wdata[31:25], bus_wdata[23:16]};
    assign dp_stat      = '{cmp: dp_cmp, msw: dp_msw, rem: dp_rem};

    for (genvar i = 0; i < N_VEC; i++) begin : g_vec
        bnacc_dbuf_reg #(.W(PTR_W)) u_vec (
            .clk(clk), .rst(rst),
            .wr(bus_we && (bus_addr == ADDR_W'(OFS_VEC0 + i))),
            .wdata(bus_wdata[PTR_W-1:0]),
            .busy(run), .load(accept),
            .active(vec_act[i])
        );
    end

    for (genvar i = 0; i < N_LEN; i++) begin : g_len
        bnacc_dbuf_reg #(.W(LEN_W)) u_len (
            .clk(clk), .rst(rst),
            .wr(bus_we && (bus_addr == ADDR_W'(OFS_LEN0 + i))),
            .wdata(bus_wdata[LEN_W-1:0]),
            .busy(run), .load(accept),
            .active(len_act[i])
        );
    end

    bnacc_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .func_wr(func_wr),
        .wr_op(bus_wdata[OP_W-1:0]),
        .wr_run(bus_wdata[RUN_BIT]),
        .wr_stall(bus_wdata[STALL_BIT]),
        .shift_wr(shift_wr),
        .wr_shift(bus_wdata[SHIFT_W-1:0]),
        .dp_done(dp_done),
        .dp_stat(dp_stat),
        .run(run), .stall(stall), .accept(accept), .start(dp_start),
        .op(op), .shift(shift), .stat(stat)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_FUNC))
            bus_rdata = {7'b0, stall, 8'b0, run, op};
        if (bus_addr == ADDR_W'(OFS_SHIFT)) bus_rdata = DATA_W'(shift);
        if (bus_addr == ADDR_W'(OFS_CMP))   bus_rdata = DATA_W'(stat.cmp);
        if (bus_addr == ADDR_W'(OFS_MSW))   bus_rdata = DATA_W'(stat.msw);
        if (bus_addr == ADDR_W'(OFS_REM))   bus_rdata = DATA_W'(stat.rem);
        for (int i = 0; i < N_VEC; i++)
            if (bus_addr == ADDR_W'(OFS_VEC0 + i)) bus_rdata = DATA_W'(vec_act[i]);
        for (int i = 0; i < N_LEN; i++)
            if (bus_addr == ADDR_W'(OFS_LEN0 + i)) bus_rdata = DATA_W'(len_act[i]);
    end

    assign dp_func  = op;
    assign dp_ptr_a = vec_act[0];
    assign dp_ptr_b = vec_act[1];
    assign dp_ptr_c = vec_act[2];
    assign dp_ptr_d = vec_act[3];
    assign dp_len_a = len_act[0];
    assign dp_len_b = len_act[1];
    assign dp_shift = shift;
    assign irq      = !run;
endmodule

// File: tb/bnacc_cmd_regs_tb.sv
module bnacc_cmd_regs_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        we = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wd = 0;
    logic        done = 0;
    logic [2:0]  cmp = 0;
    logic [15:0] msw = 0, rem = 0;
    logic [31:0] rdata;
    logic        dp_start, irq;
    logic [14:0] dp_func;
    logic [10:0] pa, pb, pc, pd;
    logic [8:0]  la, lb;
    logic [4:0]  sh;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    bnacc_cmd_regs u_dut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
        .bus_rdata(rdata), .dp_start(dp_start), .dp_func(dp_func),
        .dp_ptr_a(pa), .dp_ptr_b(pb), .dp_ptr_c(pc), .dp_ptr_d(pd),
        .dp_len_a(la), .dp_len_b(lb), .dp_shift(sh),
        .dp_done(done), .dp_cmp(cmp), .dp_msw(msw), .dp_rem(rem), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int  m_act [6];
    int  m_shd [6];
    bit  m_pv  [6];
    int  m_shift, m_op, m_cmp, m_msw, m_rem, p_cmp, p_msw, p_rem;
    bit  m_run, m_stall, m_start, m_pend;
    bit  t_acc, t_stn, t_dir, t_park, t_rel, t_fw;

    function automatic int mask_of(int i);
        return (i < 4) ? 32'h7FF : 32'h1FF;
    endfunction

    function automatic logic [31:0] m_read(int a);
        if (a == 0) return (32'(m_stall) << 24) | (32'(m_run) << 15) | m_op;
        if (a == 1) return m_shift;
        if (a >= 2 && a <= 7) return m_act[a-2];
        if (a == 8) return m_cmp;
        if (a == 9) return m_msw;
        if (a == 10) return m_rem;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 6; i++) begin m_act[i] = 0; m_shd[i] = 0; m_pv[i] = 0; end
            m_shift = 0; m_op = 0; m_cmp = 0; m_msw = 0; m_rem = 0;
            m_run = 0; m_stall = 0; m_start = 0; m_pend = 0;
        end else begin
            t_fw   = we && addr == 0;
            t_acc  = t_fw && !m_run && wd[15];
            t_stn  = (t_fw && !(m_run && wd[15])) ? wd[24] : m_stall;
            t_dir  = m_run && done && !t_stn;
            t_park = m_run && done && t_stn;
            t_rel  = m_run && m_pend && !done && !t_stn;
            for (int i = 0; i < 6; i++) begin
                if (we && addr == 4'(i + 2)) begin
                    if (!m_run) begin m_act[i] = wd & mask_of(i); m_pv[i] = 0; end
                    else begin m_shd[i] = wd & mask_of(i); m_pv[i] = 1; end
                end else if (t_acc && m_pv[i]) begin
                    m_act[i] = m_shd[i]; m_pv[i] = 0;
                end
            end
            if (we && addr == 1 && !m_run) m_shift = wd & 31;
            if (t_fw && !m_run) m_op = wd & 32'h7FFF;
            m_start = t_acc;
            if (t_dir) begin m_cmp = cmp; m_msw = msw & 16'h87FF; m_rem = rem & 16'h87FF; end
            else if (t_rel) begin m_cmp = p_cmp; m_msw = p_msw; m_rem = p_rem; end
            if (t_park) begin p_cmp = cmp; p_msw = msw & 16'h87FF; p_rem = rem & 16'h87FF; m_pend = 1; end
            else if (t_dir || t_rel) m_pend = 0;
            if (t_acc) m_run = 1; else if (t_dir || t_rel) m_run = 0;
            m_stall = t_stn;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check("R1 ptr_a", 32'(pa), m_act[0]);
            check("R1 ptr_b", 32'(pb), m_act[1]);
            check("R3 ptr_c", 32'(pc), m_act[2]);
            check("R3 ptr_d", 32'(pd), m_act[3]);
            check("R2 len_a", 32'(la), m_act[4]);
            check("R2 len_b", 32'(lb), m_act[5]);
            check("R5 shift", 32'(sh), m_shift);
            check("R6 func", 32'(dp_func), m_op);
            check("R6 start", 32'(dp_start), 32'(m_start));
            check("R10 irq", 32'(irq), 32'(!m_run));
            check("R8 rdata", rdata, m_read(int'(addr)));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(bit w, int a, logic [31:0] d, bit dn,
                        logic [2:0] c, logic [15:0] m, logic [15:0] r);
        we = w; addr = 4'(a); wd = d; done = dn; cmp = c; msw = m; rem = r;
        @(posedge clk); #1;
        we = 0; done = 0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        step(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic rd(string tag, int a, logic [31:0] exp);
        addr = 4'(a); #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R11 reset state
        check("R11 irq", 32'(irq), 1);
        check("R11 start", 32'(dp_start), 0);
        rd("R11 func", 0, 0);
        rd("R11 ptr_a", 2, 0);
        // R1 / R2 / R5 masking
        wr(2, 32'hFFFF_F123);
        check("R1 dp_ptr_a", 32'(pa), 32'h123);
        rd("R1 read a", 2, 32'h123);
        wr(3, 32'h200); wr(4, 32'h055); wr(5, 32'hFFFF_F7FF);
        wr(6, 32'hFFF); wr(7, 32'h00A);
        check("R2 dp_len_a", 32'(la), 32'h1FF);
        wr(1, 32'h3F);
        check("R5 dp_shift", 32'(sh), 31);
        // R6 start
        wr(0, 32'h0000_8010);
        check("R6 start pulse", 32'(dp_start), 1);
        check("R6 dp_func", 32'(dp_func), 32'h010);
        check("R10 irq low", 32'(irq), 0);
        // R3 / R5 / R7 during run
        wr(2, 32'h444);
        check("R6 start once", 32'(dp_start), 0);
        check("R3 ptr_a held", 32'(pa), 32'h123);
        wr(1, 3);
        check("R5 shift locked", 32'(sh), 31);
        wr(0, 32'h0000_8001);
        check("R7 func locked", 32'(dp_func), 32'h010);
        rd("R7 func read", 0, 32'h0000_8010);
        // R8 completion
        step(0, 0, 0, 1, 3'b100, 16'hFFFF, 16'h0005);
        rd("R8 run clear", 0, 32'h0000_0010);
        rd("R8 cmp", 8, 4);
        rd("R8 msw", 9, 32'h87FF);
        rd("R8 rem", 10, 5);
        check("R10 irq high", 32'(irq), 1);
        step(0, 0, 0, 1, 3'b010, 0, 0);
        rd("R8 idle done ignored", 8, 4);
        // R3 shadow applied at next start
        wr(0, 32'h0000_8020);
        check("R3 ptr_a loaded", 32'(pa), 32'h444);
        check("R3 ptr_b kept", 32'(pb), 32'h200);
        // R7 / R9 stall
        wr(0, 32'h0100_0000);
        rd("R7 stall set", 0, 32'h0100_8020);
        step(0, 0, 0, 1, 3'b001, 16'h8000, 0);
        repeat (3) step(0, 0, 0, 0, 0, 0, 0);
        rd("R9 held cmp", 8, 4);
        check("R9 held run", 32'(irq), 0);
        wr(0, 0);
        rd("R9 commit cmp", 8, 1);
        rd("R9 commit msw", 9, 32'h8000);
        rd("R9 run clear", 0, 32'h0000_0020);
        // R4 stale shadow discarded
        wr(0, 32'h0000_8004);
        wr(3, 32'h111);
        step(0, 0, 0, 1, 3'b010, 0, 0);
        wr(3, 32'h222);
        wr(0, 32'h0000_8004);
        check("R4 ptr_b", 32'(pb), 32'h222);
        step(0, 0, 0, 1, 3'b100, 0, 0);
        // R9 done together with stall release
        wr(0, 32'h0100_8200);
        step(1, 0, 0, 1, 3'b010, 16'h0001, 16'h0002);
        rd("R9 same-cycle cmp", 8, 2);
        rd("R9 same-cycle run", 0, 32'h0000_0200);
        // R3 done together with pointer write
        wr(0, 32'h0000_8008);
        step(1, 4, 32'h0AA, 1, 3'b100, 0, 0);
        check("R3 ptr_c shadowed", 32'(pc), 32'h055);
        wr(0, 32'h0000_8008);
        check("R3 ptr_c loaded", 32'(pc), 32'h0AA);
        // R9 done together with stall set
        step(1, 0, 32'h0100_0000, 1, 3'b001, 0, 0);
        rd("R9 parked cmp", 8, 4);
        wr(0, 0);
        rd("R9 released cmp", 8, 1);
        check("R10 irq after", 32'(irq), 1);
        repeat (4) step(0, 0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule